// File: doc/BRIEF.md
# Single-Accumulator 16-bit Processor

This block is a very small stored-program processor. It keeps one working value in an accumulator, and every instruction names at most one memory word. The accumulator is always the other operand and the destination. Each 16-bit instruction holds a 4-bit operation code in bits 15:12 and a 12-bit operand address in bits 11:0. A two-state controller alternates between fetching an instruction and executing it, so every instruction takes exactly two clock cycles. A stop instruction is the exception: it parks the controller in the execute state until reset.

The processor drives one word-addressed memory through an address bus, a write-data bus and read and write strobes. Writes are committed on the rising clock edge while the write strobe is high. Read data must be valid on `mem_rdata` in the same cycle that the address and read strobe are presented. Programs start at address 0 after reset.

Top module: `acc16_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the controller is in the fetch state: `mem_addr` is 0, `mem_rd` is 1, `mem_wr` is 0 and `halted` is 0. This holds whether reset is applied mid-program or after a stop.
- R2: In the fetch state, the processor reads memory at the program counter into the instruction register and advances the program counter by one. Every non-stop instruction takes one fetch cycle and one execute cycle, so the stop at program index N-1 raises `halted` in cycle 2N-1 after reset release.
- R3: Bits 15:12 of an instruction select the operation and bits 11:0 give the operand address S. In the execute state, `mem_addr` equals S.
- R4: Operation 0 loads the accumulator with mem[S].
- R5: Operation 1 writes the accumulator to mem[S]. `mem_wr` is high only in the execute cycle of this operation.
- R6: Operation 2 adds mem[S] to the accumulator modulo 2^16.
- R7: Operation 3 subtracts mem[S] from the accumulator modulo 2^16.
- R8: Operation 4 jumps unconditionally: the next fetch is from S.
- R9: Operation 5 jumps to S only when accumulator bit 15 is 0. Otherwise execution continues in sequence.
- R10: Operation 6 jumps to S only when the accumulator is non-zero.
- R11: Operation 7 stops the machine. `halted` goes high and stays high, `mem_rd` and `mem_wr` stay low, and nothing further is fetched until reset.
- R12: Operations 8 to 15 change neither the accumulator nor memory, and execution continues with the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Word address of the current memory access |
| mem_rd | output | 1 | Read strobe; data expected on mem_rdata in the same cycle |
| mem_wr | output | 1 | Write strobe; mem_wdata is stored at mem_addr on the clock edge |
| mem_wdata | output | 16 | Accumulator value presented for stores |
| mem_rdata | input | 16 | Read data from memory |
| halted | output | 1 | High while a stop instruction is held in the execute state |

## Verification
The bench builds the block with its default 16-bit word and 12-bit address field, so that it can check wrap-around results arithmetically. Eight boundary-rich values are added to and subtracted from each other in all 64 pairings, which covers carry out of bit 15, sign-bit crossings and zero. The same eight values drive both conditional jumps on each side of their sign and zero conditions. All eight unused operation codes are swept to confirm that they leave the accumulator and memory unchanged. Halt timing, quiet buses after a stop, and reset taken both mid-program and from the halted state are each checked cycle-exactly.

// File: rtl/acc16_pkg.sv
package acc16_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 4'd0,
        OP_STORE = 4'd1,
        OP_ADD   = 4'd2,
        OP_SUB   = 4'd3,
        OP_JUMP  = 4'd4,
        OP_JPOS  = 4'd5,
        OP_JNZ   = 4'd6,
        OP_STOP  = 4'd7
    } op_e;

    typedef enum logic {ST_FETCH = 1'b0, ST_EXEC = 1'b1} phase_e;
    typedef enum logic {PC_NEXT = 1'b0, PC_JUMP = 1'b1} pc_src_e;
    typedef enum logic {ADDR_PC = 1'b0, ADDR_OPND = 1'b1} addr_src_e;
    typedef enum logic [1:0] {ALU_PASS = 2'd0, ALU_ADD = 2'd1, ALU_SUB = 2'd2} alu_mode_e;

    // Eight control signals produced by the controller
    typedef struct packed {
        logic      ir_ld;
        logic      pc_ld;
        pc_src_e   pc_src;
        logic      acc_ld;
        addr_src_e addr_src;
        alu_mode_e alu_mode;
        logic      mem_rd;
        logic      mem_wr;
    } ctrl_t;

    function automatic ctrl_t fetch_ctrl();
        ctrl_t c;
        c          = '0;
        c.ir_ld    = 1'b1;
        c.pc_ld    = 1'b1;
        c.pc_src   = PC_NEXT;
        c.addr_src = ADDR_PC;
        c.alu_mode = ALU_PASS;
        c.mem_rd   = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t exec_ctrl(logic [OP_W-1:0] op, logic acc_neg, logic acc_zero);
        ctrl_t c;
        c          = '0;
        c.pc_src   = PC_JUMP;
        c.addr_src = ADDR_OPND;
        c.alu_mode = ALU_PASS;
        case (op)
            OP_LOAD: begin
                c.mem_rd = 1'b1;
                c.acc_ld = 1'b1;
            end
            OP_STORE: c.mem_wr = 1'b1;
            OP_ADD: begin
                c.mem_rd   = 1'b1;
                c.acc_ld   = 1'b1;
                c.alu_mode = ALU_ADD;
            end
            OP_SUB: begin
                c.mem_rd   = 1'b1;
                c.acc_ld   = 1'b1;
                c.alu_mode = ALU_SUB;
            end
            OP_JUMP: c.pc_ld = 1'b1;
            OP_JPOS: c.pc_ld = ~acc_neg;
            OP_JNZ:  c.pc_ld = ~acc_zero;
            default: c.pc_ld = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc16_alu.sv
module acc16_alu
    import acc16_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter bit SHARED_ADDER = 1'b1
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_mode_e         mode,
    output logic [DATA_W-1:0] y
);

    generate
        if (SHARED_ADDER) begin : g_shared
            logic [DATA_W-1:0] b_eff;
            logic [DATA_W-1:0] carry_in;
            logic [DATA_W-1:0] sum;
            always_comb begin
                b_eff    = (mode == ALU_SUB) ? ~b : b;
                carry_in = {{(DATA_W-1){1'b0}}, (mode == ALU_SUB)};
                sum      = a + b_eff + carry_in;
                y        = (mode == ALU_PASS) ? b : sum;
            end
        end else begin : g_split
            always_comb begin
                case (mode)
                    ALU_ADD: y = a + b;
                    ALU_SUB: y = a - b;
                    default: y = b;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/acc16_ctrl.sv
module acc16_ctrl
    import acc16_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            acc_neg,
    input  logic            acc_zero,
    output ctrl_t           ctl,
    output logic            halted
);

    phase_e phase;
    phase_e phase_nx;

    always_comb begin
        if (phase == ST_FETCH) begin
            ctl      = fetch_ctrl();
            phase_nx = ST_EXEC;
        end else begin
            ctl      = exec_ctrl(opcode, acc_neg, acc_zero);
            phase_nx = (opcode == OP_STOP) ? ST_EXEC : ST_FETCH;
        end
    end

    assign halted = (phase == ST_EXEC) && (opcode == OP_STOP);

    always_ff @(posedge clk) begin
        if (rst) phase <= ST_FETCH;
        else     phase <= phase_nx;
    end

    a_r1_reset_to_fetch: assert property (@(posedge clk)
        rst |=> (phase == ST_FETCH));

    a_r2_fetch_then_exec: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_FETCH) |=> (phase == ST_EXEC));

    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && phase == ST_EXEC));

endmodule

// File: rtl/acc16_datapath.sv
module acc16_datapath
    import acc16_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter bit SHARED_ADDER = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-OP_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [OP_W-1:0]   opcode,
    output logic              acc_neg,
    output logic              acc_zero
);

    localparam int ADDR_W = DATA_W - OP_W;

    logic [DATA_W-1:0] ir;
    logic [DATA_W-1:0] acc;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] operand;
    logic [DATA_W-1:0] alu_y;

    assign operand  = ir[ADDR_W-1:0];
    assign opcode   = ir[DATA_W-1:ADDR_W];
    assign acc_neg  = acc[DATA_W-1];
    assign acc_zero = (acc == '0);
    assign mem_addr  = (ctl.addr_src == ADDR_PC) ? pc : operand;
    assign mem_wdata = acc;

    acc16_alu #(
        .DATA_W      (DATA_W),
        .SHARED_ADDER(SHARED_ADDER)
    ) u_alu (
        .a   (acc),
        .b   (mem_rdata),
        .mode(ctl.alu_mode),
        .y   (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ir  <= '0;
            acc <= '0;
            pc  <= '0;
        end else begin
            if (ctl.ir_ld)  ir  <= mem_rdata;
            if (ctl.acc_ld) acc <= alu_y;
            if (ctl.pc_ld)  pc  <= (ctl.pc_src == PC_JUMP) ? operand : pc + 1'b1;
        end
    end

    a_r2_pc_increment: assert property (@(posedge clk) disable iff (rst)
        (ctl.pc_ld && ctl.pc_src == PC_NEXT) |=> (pc == $past(pc) + 1'b1));

    a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
        (ctl.pc_ld && ctl.pc_src == PC_JUMP) |=> (pc == $past(operand)));

    a_r12_acc_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl.acc_ld |=> $stable(acc));

endmodule

// File: rtl/acc16_core.sv
module acc16_core
    import acc16_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter bit SHARED_ADDER = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    output logic [DATA_W-OP_W-1:0] mem_addr,
    output logic                   mem_rd,
    output logic                   mem_wr,
    output logic [DATA_W-1:0]      mem_wdata,
    input  logic [DATA_W-1:0]      mem_rdata,
    output logic                   halted
);

    ctrl_t           ctl;
    logic [OP_W-1:0] opcode;
    logic            acc_neg;
    logic            acc_zero;

    acc16_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .opcode  (opcode),
        .acc_neg (acc_neg),
        .acc_zero(acc_zero),
        .ctl     (ctl),
        .halted  (halted)
    );

    acc16_datapath #(
        .DATA_W      (DATA_W),
        .SHARED_ADDER(SHARED_ADDER)
    ) u_dp (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .mem_rdata(mem_rdata),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .opcode   (opcode),
        .acc_neg  (acc_neg),
        .acc_zero (acc_zero)
    );

    assign mem_rd = ctl.mem_rd;
    assign mem_wr = ctl.mem_wr;

    a_r11_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !mem_wr));

    a_r5_no_read_on_write: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> !mem_rd);

endmodule

// File: tb/sim_acc16_core.sv
`timescale 1ns/1ps
module sim_acc16_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        halted;

    logic [15:0] mem [0:255];
    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    acc16_core u0 (
        .clk      (clk),
        .rst      (rst),
        .mem_addr (mem_addr),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .halted   (halted)
    );

    always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    assign mem_rdata = mem[mem_addr[7:0]];

    localparam logic [15:0] VALS [0:7] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                           16'hFFFF, 16'h1234, 16'h00FF, 16'hABCD};

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic put(input int a, input logic [3:0] op, input logic [11:0] s);
        mem[a] = {op, s};
    endtask

    // Reset then check cycle 0 (R1)
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(mem_addr == 12'd0 && mem_rd && !mem_wr && !halted, "R1", "in reset",
              {4'h0, mem_addr}, 16'h0000);
        rst = 1'b0;
        check(mem_addr == 12'd0 && mem_rd && !mem_wr && !halted, "R1", "cycle0",
              {4'h0, mem_addr}, 16'h0000);
    endtask

    task automatic run_to_halt(output int cyc);
        cyc = 0;
        while (!halted && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        check(halted, "R11", "halt reached", {15'd0, halted}, 16'h0001);
    endtask

    task automatic load_arith(input logic [15:0] a, input logic [15:0] b);
        clear_mem();
        put(0, 4'd0, 12'd20);
        put(1, 4'd2, 12'd21);
        put(2, 4'd1, 12'd30);
        put(3, 4'd0, 12'd20);
        put(4, 4'd3, 12'd21);
        put(5, 4'd1, 12'd31);
        put(6, 4'd7, 12'd0);
        mem[20] = a;
        mem[21] = b;
    endtask

    initial begin
        int cyc;
        logic [15:0] exp;

        // R4 R5 R6 R7 R2: all pairings of boundary values
        foreach (VALS[i]) begin
            foreach (VALS[j]) begin
                load_arith(VALS[i], VALS[j]);
                do_reset();
                run_to_halt(cyc);
                check(cyc == 13, "R2", "halt cycle", cyc[15:0], 16'd13);
                exp = VALS[i] + VALS[j];
                check(mem[30] == exp, "R6", "sum", mem[30], exp);
                exp = VALS[i] - VALS[j];
                check(mem[31] == exp, "R7", "difference", mem[31], exp);
                check(mem[21] == VALS[j], "R4", "operand kept", mem[21], VALS[j]);
            end
        end

        // R11: bus stays quiet and halt held
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check(halted && !mem_rd && !mem_wr, "R11", "halt held",
                  {13'd0, halted, mem_rd, mem_wr}, 16'h0004);
        end

        // R1: reset mid-program, then result still correct
        load_arith(16'h0005, 16'h0003);
        do_reset();
        repeat (5) @(negedge clk);
        do_reset();
        run_to_halt(cyc);
        check(cyc == 13, "R1", "restart timing", cyc[15:0], 16'd13);
        check(mem[30] == 16'h0008, "R1", "restart sum", mem[30], 16'h0008);

        // R8 R9 R10: jumps across sign and zero boundaries
        foreach (VALS[i]) begin
            clear_mem();
            put(0, 4'd0, 12'd20);
            put(1, 4'd5, 12'd4);
            put(2, 4'd0, 12'd22);
            put(3, 4'd4, 12'd5);
            put(4, 4'd0, 12'd23);
            put(5, 4'd1, 12'd30);
            put(6, 4'd0, 12'd20);
            put(7, 4'd6, 12'd10);
            put(8, 4'd0, 12'd22);
            put(9, 4'd4, 12'd11);
            put(10, 4'd0, 12'd23);
            put(11, 4'd1, 12'd31);
            put(12, 4'd0, 12'd20);
            put(13, 4'd4, 12'd15);
            put(14, 4'd1, 12'd32);
            put(15, 4'd1, 12'd33);
            put(16, 4'd7, 12'd0);
            mem[20] = VALS[i];
            mem[22] = 16'h0A0A;
            mem[23] = 16'h0B0B;
            do_reset();
            run_to_halt(cyc);
            exp = VALS[i][15] ? 16'h0A0A : 16'h0B0B;
            check(mem[30] == exp, "R9", "jump if non-negative", mem[30], exp);
            exp = (VALS[i] != 16'h0000) ? 16'h0B0B : 16'h0A0A;
            check(mem[31] == exp, "R10", "jump if non-zero", mem[31], exp);
            check(mem[32] == 16'h0000, "R8", "skipped store", mem[32], 16'h0000);
            check(mem[33] == VALS[i], "R8", "jump landing", mem[33], VALS[i]);
        end

        // R12 R3: unused operation codes do nothing
        for (int op = 8; op < 16; op++) begin
            clear_mem();
            put(0, 4'd0, 12'd20);
            put(1, op[3:0], 12'd21);
            put(2, 4'd1, 12'd30);
            put(3, 4'd7, 12'd0);
            mem[20] = 16'h5A5A;
            mem[21] = 16'h1111;
            do_reset();
            run_to_halt(cyc);
            check(cyc == 7, "R12", "no-op timing", cyc[15:0], 16'd7);
            check(mem[30] == 16'h5A5A, "R12", "acc unchanged", mem[30], 16'h5A5A);
            check(mem[21] == 16'h1111, "R12", "memory unchanged", mem[21], 16'h1111);
        end

        // R3 R5: execute cycle addresses S, write only there
        clear_mem();
        put(0, 4'd1, 12'hABC);
        put(1, 4'd7, 12'd0);
        do_reset();
        @(negedge clk);
        check(mem_addr == 12'hABC && mem_wr && !mem_rd, "R3", "exec address",
              {4'h0, mem_addr}, 16'h0ABC);
        @(negedge clk);
        check(mem_addr == 12'd1 && !mem_wr && mem_rd, "R5", "fetch after store",
              {4'h0, mem_addr}, 16'h0001);

        // R1: reset from halted state
        @(negedge clk);
        check(halted, "R11", "stopped", {15'd0, halted}, 16'h0001);
        do_reset();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%h expected=%h", 16'h0000, 16'h0001);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule